// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register side of a power-management companion device. A serial bus slave decodes a frame into a register index, a direction and 16 bits of data, and presents it on a one-cycle parallel strobe. There are 32 register indices. They hold an identification word, an interrupt status register with a mask, a bank of ADC results read through a channel selector, a control word, a watchdog register with a shutdown request, a key/event status word, and plain storage. No analog conversion takes place. The ADC results are a table loaded at reset, and the headset and hook events rewrite two of its entries.

Read data is combinational from `addr_i`, so the serial slave can pick up a word in the same cycle it presents the index. Writes and event pulses take effect at the next rising clock edge. The interrupt line and the shutdown request are driven from registered state.

Top module: `pmic_regfile`

## Requirements
- R1: Index 0x00 reads 0x0215 when `variant_i` is low and 0x0295 when it is high. Writes to it have no effect.
- R2: `irq_o` is high exactly when some bit of the interrupt status is 1 and the same bit of the mask register (index 0x02, read/write, reset 0) is 0.
- R3: Reading index 0x01 returns the interrupt status (reset 0). Writing it clears every status bit written as 1 and keeps every bit written as 0. An event that sets a bit in the same cycle wins over the clear.
- R4: A write to index 0x08 loads the ADC channel from write data bits [13:10] and sets interrupt status bit 8.
- R5: A read of index 0x08 returns 0 in bits [15:14], the selected channel in bits [13:10] and that channel's 10-bit result in bits [9:0].
- R6: After reset the channel is 0 and the results are: ch1 0x3C2, ch2 0x0FC, ch3 0x165, ch4 123, ch5 1023, ch6 0x011, ch7 0x011, ch8 0x250, ch10 2, ch11 0x011, ch12 0x3D0, ch13 0x330. All other channels are 0.
- R7: Writing 0 to the watchdog index 0x17 while bit 1 of the control word at index 0x0D is 1 raises `shutdown_o`, which stays high until reset. A nonzero write, or a write with that control bit at 0, does not raise it.
- R8: A key event pulse sets interrupt status bit 0. It also sets bit 5 of the read-only status word at index 0x16 (reset 0x0020) to the inverse of `key_state_i`. Writes to 0x16 have no effect.
- R9: A headset event sets interrupt status bit 7 and a hook event sets bit 6, but only when bits 8 and 10 of the control word are both 1.
- R10: A headset event sets ADC channel 4, and a hook event sets channel 5, to 50 when its state input is high and to 123 when it is low. This happens whatever the control word holds.
- R11: An access to an undefined index (0x07, 0x12 to 0x15) reads 0 and writes nothing, and it sets `addr_err_o`, which stays high until reset.
- R12: Every other index (0x03 to 0x06, 0x09 to 0x11, 0x17 to 0x1F) is a 16-bit read/write register that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | Selects the identification variant |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| key_evt_i | input | 1 | Power key event pulse |
| key_state_i | input | 1 | Power key level, 1 = pressed |
| head_evt_i | input | 1 | Headset event pulse |
| head_state_i | input | 1 | Headset level, 1 = inserted |
| hook_evt_i | input | 1 | Hook event pulse |
| hook_state_i | input | 1 | Hook level, 1 = active |
| irq_o | output | 1 | Unmasked interrupt pending |
| shutdown_o | output | 1 | Sticky shutdown request |
| addr_err_o | output | 1 | Sticky undefined-index flag |

## Verification
The assertions check on every cycle that ADC writes and key events set their status bits, that a clear with no competing set removes a bit, and that the headset bit never rises without an enabled event. They also check that both sticky flags hold and that each headset event leaves the encoded level in channel 4. Other behaviour needs the bench's scenarios. These cover the full reset table through a sweep of all 16 channels, a sweep of all 32 indices against the read/write, read-only and undefined kinds, and the watchdog arming order. They also cover the masking combinations, set winning over a clear in the same cycle, and event gating through the control word.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int DW     = 16;
  localparam int AW     = 5;
  localparam int NREG   = 32;
  localparam int NCH    = 16;
  localparam int CH_W   = 4;
  localparam int RES_W  = 10;

  localparam logic [AW-1:0] IDX_ID     = 5'h00;
  localparam logic [AW-1:0] IDX_IRQ_ST = 5'h01;
  localparam logic [AW-1:0] IDX_MASK   = 5'h02;
  localparam logic [AW-1:0] IDX_ADC    = 5'h08;
  localparam logic [AW-1:0] IDX_CTL1   = 5'h0D;
  localparam logic [AW-1:0] IDX_STATUS = 5'h16;
  localparam logic [AW-1:0] IDX_WDOG   = 5'h17;

  localparam logic [DW-1:0] ID_BASE   = 16'h0215;
  localparam int ID_VARIANT_BIT       = 7;

  localparam int IRQ_KEY  = 0;
  localparam int IRQ_HOOK = 6;
  localparam int IRQ_HEAD = 7;
  localparam int IRQ_ADC  = 8;

  localparam int CH_HEAD = 4;
  localparam int CH_HOOK = 5;
  localparam int RES_ACTIVE = 50;
  localparam int RES_IDLE   = 123;

  localparam int STAT_KEY_BIT = 5;
  localparam logic [DW-1:0] STAT_RESET = 16'h0020;

  localparam int CTL_WDOG_EN = 1;
  localparam int CTL_ACC_A   = 8;
  localparam int CTL_ACC_B   = 10;

  typedef enum logic [2:0] {
    K_ID, K_IRQ_ST, K_MASK, K_ADC, K_STATUS, K_PLAIN, K_NONE
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [AW-1:0] a);
    case (a)
      IDX_ID:     return K_ID;
      IDX_IRQ_ST: return K_IRQ_ST;
      IDX_MASK:   return K_MASK;
      IDX_ADC:    return K_ADC;
      IDX_STATUS: return K_STATUS;
      5'h07, 5'h12, 5'h13, 5'h14, 5'h15: return K_NONE;
      default:    return K_PLAIN;
    endcase
  endfunction

  function automatic logic [RES_W-1:0] adc_default(input int ch);
    case (ch)
      1:          return 10'h3C2;
      2:          return 10'h0FC;
      3:          return 10'h165;
      4:          return 10'd123;
      5:          return 10'd1023;
      6, 7, 11:   return 10'h011;
      8:          return 10'h250;
      10:         return 10'd2;
      12:         return 10'h3D0;
      13:         return 10'h330;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/pmic_irq.sv
module pmic_irq #(
  parameter int DW = pmic_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] st_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  import pmic_pkg::*;

  logic [DW-1:0] st_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      mask_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_vec) | set_i;  // set wins over clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
  assign irq_o  = |(st_q & ~mask_q);

  AST_ADC_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[IRQ_ADC] |=> st_q[IRQ_ADC]);  // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wdata_i[IRQ_HEAD] && !set_i[IRQ_HEAD]) |=> !st_q[IRQ_HEAD]);  // R3
endmodule

// File: rtl/pmic_adc.sv
module pmic_adc #(
  parameter int NCH   = pmic_pkg::NCH,
  parameter int CH_W  = pmic_pkg::CH_W,
  parameter int RES_W = pmic_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_we_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             head_evt_i,
  input  logic             head_state_i,
  input  logic             hook_evt_i,
  input  logic             hook_state_i,
  output logic [CH_W-1:0]  ch_o,
  output logic [RES_W-1:0] res_o
);
  import pmic_pkg::*;

  localparam logic [RES_W-1:0] V_ACT  = RES_W'(RES_ACTIVE);
  localparam logic [RES_W-1:0] V_IDLE = RES_W'(RES_IDLE);

  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] res_q [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else if (ch_we_i) ch_q <= ch_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == CH_HEAD || c == CH_HOOK) begin : g_evt
      logic evt, lvl;
      assign evt = (c == CH_HEAD) ? head_evt_i : hook_evt_i;
      assign lvl = (c == CH_HEAD) ? head_state_i : hook_state_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q[c] <= adc_default(c);
        else if (evt) res_q[c] <= lvl ? V_ACT : V_IDLE;
      end
    end else begin : g_fix
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q[c] <= adc_default(c);
      end
    end
  end

  assign ch_o  = ch_q;
  assign res_o = res_q[ch_q];

  AST_HEAD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_evt_i |=> (res_q[CH_HEAD] == ($past(head_state_i) ? V_ACT : V_IDLE)));  // R10
endmodule

// File: rtl/pmic_store.sv
module pmic_store #(
  parameter int DW   = pmic_pkg::DW,
  parameter int AW   = pmic_pkg::AW,
  parameter int NREG = pmic_pkg::NREG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ctl1_o
);
  import pmic_pkg::*;

  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (kind_of(AW'(i)) == K_PLAIN) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem[i] <= '0;
        else if (we_i && addr_i == AW'(i)) mem[i] <= wdata_i;
      end
    end else begin : g_none
      assign mem[i] = '0;
    end
  end

  assign rdata_o = mem[addr_i];
  assign ctl1_o  = mem[IDX_CTL1];
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile #(
  parameter int DW = pmic_pkg::DW,
  parameter int AW = pmic_pkg::AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          variant_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          key_evt_i,
  input  logic          key_state_i,
  input  logic          head_evt_i,
  input  logic          head_state_i,
  input  logic          hook_evt_i,
  input  logic          hook_state_i,
  output logic          irq_o,
  output logic          shutdown_o,
  output logic          addr_err_o
);
  import pmic_pkg::*;

  localparam int ADC_LSB = RES_W;

  reg_kind_e     kind;
  logic          wr, acc_en, wdog_fire;
  logic [DW-1:0] set_vec, irq_st, irq_mask, store_rd, ctl1, stat_q, id_val;
  logic [CH_W-1:0]  adc_ch;
  logic [RES_W-1:0] adc_res;
  logic          shut_q, err_q;

  assign kind   = kind_of(addr_i);
  assign wr     = req_i && we_i;
  assign acc_en = ctl1[CTL_ACC_A] && ctl1[CTL_ACC_B];

  always_comb begin
    set_vec           = '0;
    set_vec[IRQ_KEY]  = key_evt_i;
    set_vec[IRQ_HEAD] = head_evt_i && acc_en;
    set_vec[IRQ_HOOK] = hook_evt_i && acc_en;
    set_vec[IRQ_ADC]  = wr && kind == K_ADC;
  end

  pmic_irq #(.DW(DW)) u_irq (
    .clk_i, .rst_ni,
    .set_i     (set_vec),
    .clr_we_i  (wr && kind == K_IRQ_ST),
    .mask_we_i (wr && kind == K_MASK),
    .wdata_i,
    .st_o      (irq_st),
    .mask_o    (irq_mask),
    .irq_o
  );

  pmic_adc u_adc (
    .clk_i, .rst_ni,
    .ch_we_i   (wr && kind == K_ADC),
    .ch_i      (wdata_i[ADC_LSB +: CH_W]),
    .head_evt_i, .head_state_i, .hook_evt_i, .hook_state_i,
    .ch_o      (adc_ch),
    .res_o     (adc_res)
  );

  pmic_store #(.DW(DW), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .we_i      (wr && kind == K_PLAIN),
    .addr_i, .wdata_i,
    .rdata_o   (store_rd),
    .ctl1_o    (ctl1)
  );

  assign wdog_fire = wr && addr_i == IDX_WDOG && wdata_i == '0 && ctl1[CTL_WDOG_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RESET;
      shut_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (key_evt_i) stat_q[STAT_KEY_BIT] <= ~key_state_i;
      if (wdog_fire) shut_q <= 1'b1;
      if (req_i && kind == K_NONE) err_q <= 1'b1;
    end
  end

  always_comb begin
    id_val = ID_BASE;
    id_val[ID_VARIANT_BIT] = ID_BASE[ID_VARIANT_BIT] | variant_i;
    case (kind)
      K_ID:     rdata_o = id_val;
      K_IRQ_ST: rdata_o = irq_st;
      K_MASK:   rdata_o = irq_mask;
      K_ADC:    rdata_o = DW'({adc_ch, adc_res});
      K_STATUS: rdata_o = stat_q;
      K_PLAIN:  rdata_o = store_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign shutdown_o = shut_q;
  assign addr_err_o = err_q;

  AST_KEY_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_i |=> irq_st[IRQ_KEY]);  // R8
  AST_HEAD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(head_evt_i && ctl1[CTL_ACC_A] && ctl1[CTL_ACC_B]) |=> !$rose(irq_st[IRQ_HEAD]));  // R9
  AST_SHUTDOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);  // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |=> addr_err_o);  // R11
endmodule

// File: tb/pmic_regfile_test.sv
`timescale 1ns/1ps
module pmic_regfile_test;
  logic clk = 0, rst_n = 0;
  logic variant = 0, req = 0, we = 0;
  logic [4:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic key_evt = 0, key_st = 0, head_evt = 0, head_st = 0, hook_evt = 0, hook_st = 0;
  logic irq, shut, err;
  int n_run = 0, n_fail = 0;
  logic [15:0] v;

  always #4 clk = ~clk;

  pmic_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .key_evt_i(key_evt), .key_state_i(key_st), .head_evt_i(head_evt),
    .head_state_i(head_st), .hook_evt_i(hook_evt), .hook_state_i(hook_st),
    .irq_o(irq), .shutdown_o(shut), .addr_err_o(err)
  );

  function automatic logic [9:0] exp_res(int ch);
    case (ch)
      1: return 10'h3C2;  2: return 10'h0FC;  3: return 10'h165;
      4: return 10'd123;  5: return 10'd1023; 6: return 10'h011;
      7: return 10'h011;  8: return 10'h250;  10: return 10'd2;
      11: return 10'h011; 12: return 10'h3D0; 13: return 10'h330;
      default: return 10'd0;
    endcase
  endfunction

  function automatic bit undef_idx(int a);
    return a == 7 || (a >= 'h12 && a <= 'h15);
  endfunction

  task automatic chk(string r, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic ev_key(logic s);
    @(negedge clk); key_evt = 1; key_st = s;
    @(negedge clk); key_evt = 0;
  endtask
  task automatic ev_head(logic s);
    @(negedge clk); head_evt = 1; head_st = s;
    @(negedge clk); head_evt = 0;
  endtask
  task automatic ev_hook(logic s);
    @(negedge clk); hook_evt = 1; hook_st = s;
    @(negedge clk); hook_evt = 0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R2 irq reset", {15'd0, irq}, 16'd0);
    chk("R7 shutdown reset", {15'd0, shut}, 16'd0);
    chk("R11 err reset", {15'd0, err}, 16'd0);
    rd(5'h01, v); chk("R3 status reset", v, 16'h0000);
    rd(5'h02, v); chk("R2 mask reset", v, 16'h0000);
    rd(5'h16, v); chk("R8 status word reset", v, 16'h0020);
    rd(5'h08, v); chk("R6 channel reset", v, 16'h0000);

    // R1 identification
    rd(5'h00, v); chk("R1 id", v, 16'h0215);
    wr(5'h00, 16'hFFFF);
    rd(5'h00, v); chk("R1 id write ignored", v, 16'h0215);
    variant = 1;
    rd(5'h00, v); chk("R1 id variant", v, 16'h0295);
    variant = 0;

    // R4 R5 R6 channel sweep
    for (int ch = 0; ch < 16; ch++) begin
      wr(5'h08, 16'(ch << 10) | 16'hC3FF);
      rd(5'h08, v); chk("R5 R6 adc read", v, 16'(ch << 10) | {6'd0, exp_res(ch)});
    end
    rd(5'h01, v); chk("R4 adc irq bit", v, 16'h0100);
    chk("R2 irq unmasked", {15'd0, irq}, 16'd1);
    wr(5'h02, 16'h0100);
    chk("R2 irq masked", {15'd0, irq}, 16'd0);
    rd(5'h02, v); chk("R2 mask readback", v, 16'h0100);
    wr(5'h01, 16'h0100);
    rd(5'h01, v); chk("R3 w1c", v, 16'h0000);
    wr(5'h02, 16'h0000);

    // index sweep R11 R12 R8
    chk("R11 err before sweep", {15'd0, err}, 16'd0);
    for (int a = 0; a < 32; a++) begin
      logic [15:0] pat;
      pat = 16'(a * 16'h0101) ^ 16'h5A5A;
      if (a == 0 || a == 1 || a == 2 || a == 8) continue;
      wr(5'(a), pat);
      rd(5'(a), v);
      if (undef_idx(a)) chk("R11 undefined reads zero", v, 16'h0000);
      else if (a == 'h16) chk("R8 status read-only", v, 16'h0020);
      else chk("R12 plain rw", v, pat);
    end
    chk("R11 err sticky", {15'd0, err}, 16'd1);
    chk("R7 no shutdown on nonzero", {15'd0, shut}, 16'd0);

    // R7 watchdog
    wr(5'h0D, 16'h0000);
    wr(5'h17, 16'h0000);
    chk("R7 disarmed zero write", {15'd0, shut}, 16'd0);
    wr(5'h0D, 16'h0002);
    wr(5'h17, 16'h0005);
    chk("R7 armed nonzero write", {15'd0, shut}, 16'd0);
    wr(5'h17, 16'h0000);
    chk("R7 armed zero write", {15'd0, shut}, 16'd1);
    wr(5'h17, 16'h0007);
    chk("R7 shutdown holds", {15'd0, shut}, 16'd1);

    // R8 key
    ev_key(1);
    rd(5'h01, v); chk("R8 key irq bit", v, 16'h0001);
    rd(5'h16, v); chk("R8 key pressed", v, 16'h0000);
    ev_key(0);
    rd(5'h16, v); chk("R8 key released", v, 16'h0020);
    wr(5'h01, 16'hFFFF);
    // R3 set wins over clear
    @(negedge clk); req = 1; we = 1; addr = 5'h01; wdata = 16'h0001; key_evt = 1; key_st = 0;
    @(negedge clk); req = 0; we = 0; key_evt = 0;
    rd(5'h01, v); chk("R3 set wins", v, 16'h0001);
    wr(5'h01, 16'hFFFF);

    // R9 R10 events, gate closed
    ev_head(1);
    ev_hook(1);
    rd(5'h01, v); chk("R9 gated off", v, 16'h0000);
    wr(5'h08, 16'(4 << 10));
    rd(5'h08, v); chk("R10 head active", v, 16'(4 << 10) | 16'd50);
    wr(5'h08, 16'(5 << 10));
    rd(5'h08, v); chk("R10 hook active", v, 16'(5 << 10) | 16'd50);
    wr(5'h01, 16'hFFFF);
    // gate open
    wr(5'h0D, 16'h0100);
    ev_head(1);
    rd(5'h01, v); chk("R9 one gate bit", v, 16'h0000);
    wr(5'h0D, 16'h0500);
    ev_head(0);
    rd(5'h01, v); chk("R9 head irq", v, 16'h0080);
    ev_hook(0);
    rd(5'h01, v); chk("R9 hook irq", v, 16'h00C0);
    rd(5'h08, v); chk("R10 hook idle", v, 16'(5 << 10) | 16'd123);
    wr(5'h08, 16'(4 << 10));
    rd(5'h08, v); chk("R10 head idle", v, 16'(4 << 10) | 16'd123);
    wr(5'h01, 16'h0100);
    wr(5'h02, 16'h0040);
    chk("R2 partial mask", {15'd0, irq}, 16'd1);
    wr(5'h02, 16'h00C0);
    chk("R2 full mask", {15'd0, irq}, 16'd0);
    wr(5'h01, 16'h0080);
    wr(5'h02, 16'h0000);
    chk("R2 after clear", {15'd0, irq}, 16'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule